// File: doc/BRIEF.md
# Flash Direct-Read Access Guard

This block filters memory-mapped reads headed for a serial flash device. Four controllers share it: the host firmware path, the Ethernet path, the management engine and the embedded controller. Each request carries a controller index, a requester ID, a controller-relative byte address and a write flag. The guard adds the selected controller's region base to the address to form a flash linear address. It grants the request only if all of the following hold: the request is a read, the requester ID equals that controller's configured owner ID, the region is enabled, and the linear address lies inside the region. A denied request gets an error response and never reaches the flash engine.

A granted read is served from a single-line cache, 64 bytes by default. On a miss the guard fetches the whole line from the flash read engine through a valid/ready request and a data-return strobe, fills the cache, and then answers. The cache is shared by all controllers. When a granted read comes from a controller other than the last one served, the cache is invalidated and its storage is zeroed, so a line fetched for one controller is never handed to another.

Top module: `flash_dr_guard`

## Requirements
- R1: A request with the write flag set is always refused: error response, read data all ones, and no flash fetch. It also leaves the cache untouched.
- R2: A read whose requester ID differs from the owner ID configured for the selected controller is refused.
- R3: The region holds the linear addresses from base×4 KB up to (limit+1)×4 KB−1 inclusive. The last byte of the region is granted, and the first byte past it is refused.
- R4: The linear address is the controller's region base (in 4 KB blocks) shifted left by 12, plus the request address. A fetch presents this address with its low 6 bits cleared.
- R5: A region whose limit is below its base is disabled, and every read to it is refused.
- R6: A refused request gives rsp_valid with rsp_err=1 and rsp_data all ones, one cycle after acceptance, and it raises no flash request.
- R7: A granted read that hits the cached line, from the same controller as the last one served, responds one cycle after acceptance with rsp_err=0 and issues no fetch.
- R8: A granted miss raises fl_req_valid with a stable address until fl_req_ready. req_ready stays low until the response, and the response follows the returned line.
- R9: A granted read from a controller other than the last one served wipes the cache, so it fetches even if another controller just loaded the same line. Refused requests do not count as served.
- R10: During and right after reset, req_ready=1, rsp_valid=0, fl_req_valid=0, and the cache is empty.
- R11: Response data is 32-bit word number addr[5:2] of the line, where word k occupies line bits 32k+31 down to 32k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Guard idle and able to accept |
| req_ctrl | input | 2 | Controller index 0..3 |
| req_id | input | 8 | Requester ID |
| req_addr | input | 24 | Controller-relative byte address |
| req_write | input | 1 | 1 = write request |
| cfg_base | input | 60 | Region base in 4 KB blocks, 15 bits per controller, controller 0 lowest |
| cfg_limit | input | 60 | Region limit in 4 KB blocks, inclusive, same packing |
| cfg_owner | input | 32 | Owner ID, 8 bits per controller |
| rsp_valid | output | 1 | Response strobe, one cycle |
| rsp_err | output | 1 | Request refused |
| rsp_data | output | 32 | Read word, all ones on refusal |
| fl_req_valid | output | 1 | Line fetch request to flash engine |
| fl_req_ready | input | 1 | Flash engine accepts fetch |
| fl_req_addr | output | 27 | Line-aligned linear address of fetch |
| fl_rsp_valid | input | 1 | Line data strobe from flash engine |
| fl_rsp_data | input | 512 | Returned line |

## Verification
Refusals and cache hits are due exactly one cycle after the accepting edge. A miss raises its fetch in the first cycle after acceptance, and its response comes one cycle after the edge that samples fl_rsp_valid. The bench drives on falling edges and samples on falling edges. It counts falling edges from acceptance to rsp_valid and demands a count of exactly one for refusals and hits. It uses the count of fetches the flash model has accepted to decide whether a fetch happened. Cache wiping and the untouched state after refusals are observed at the ports, through whether the next read fetches.

// File: rtl/flash_dr_pkg.sv
package flash_dr_pkg;

   // Controller slots, fixed order of the cfg_* packing
   typedef enum logic [1:0] {
      CTRL_HOST = 2'd0,
      CTRL_NET  = 2'd1,
      CTRL_MGMT = 2'd2,
      CTRL_EMBC = 2'd3
   } ctrl_e;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_FETCH = 2'd1,
      ST_WAIT  = 2'd2,
      ST_RESP  = 2'd3
   } guard_st_e;

   localparam int MIN_BLK_SHIFT = 12;

endpackage

// File: rtl/flash_dr_region_chk.sv
module flash_dr_region_chk #(
   parameter int NCTRL     = 4,
   parameter int CTRL_W    = 2,
   parameter int ID_W      = 8,
   parameter int ADDR_W    = 24,
   parameter int FLA_W     = 27,
   parameter int BLK_SHIFT = 12,
   parameter int BLK_W     = FLA_W - BLK_SHIFT
) (
   input  logic [CTRL_W-1:0]       sel,
   input  logic [ID_W-1:0]         req_id,
   input  logic [ADDR_W-1:0]       req_addr,
   input  logic                    req_write,
   input  logic [NCTRL*BLK_W-1:0]  cfg_base,
   input  logic [NCTRL*BLK_W-1:0]  cfg_limit,
   input  logic [NCTRL*ID_W-1:0]   cfg_owner,
   output logic [FLA_W-1:0]        fla,
   output logic                    grant
);

   logic [BLK_W-1:0] base_a  [NCTRL];
   logic [BLK_W-1:0] limit_a [NCTRL];
   logic [ID_W-1:0]  owner_a [NCTRL];

   for (genvar g = 0; g < NCTRL; g++) begin : g_unpack
      assign base_a[g]  = cfg_base[g*BLK_W +: BLK_W];
      assign limit_a[g] = cfg_limit[g*BLK_W +: BLK_W];
      assign owner_a[g] = cfg_owner[g*ID_W +: ID_W];
   end

   logic [BLK_W-1:0] sel_base, sel_lim;
   logic [ID_W-1:0]  sel_owner;
   logic [FLA_W:0]   fla_x;
   logic [BLK_W:0]   blk;
   logic             id_ok, enabled, in_rng;

   always_comb begin
      sel_base  = base_a[sel];
      sel_lim   = limit_a[sel];
      sel_owner = owner_a[sel];
      // one spare bit catches wrap past the top of flash
      fla_x     = {1'b0, sel_base, {BLK_SHIFT{1'b0}}}
                + {{(FLA_W+1-ADDR_W){1'b0}}, req_addr};
      blk       = fla_x[FLA_W:BLK_SHIFT];
      id_ok     = (req_id == sel_owner);
      enabled   = (sel_lim >= sel_base);
      in_rng    = (blk >= {1'b0, sel_base}) && (blk <= {1'b0, sel_lim});
      grant     = !req_write && id_ok && enabled && in_rng;
      fla       = fla_x[FLA_W-1:0];
   end

endmodule

// File: rtl/flash_dr_line_cache.sv
module flash_dr_line_cache #(
   parameter int LINE_BITS = 512,
   parameter int DATA_W    = 32,
   parameter int TAG_W     = 21,
   parameter int WSEL_W    = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wipe,
   input  logic                 fill,
   input  logic [TAG_W-1:0]     fill_tag,
   input  logic [LINE_BITS-1:0] fill_line,
   input  logic [TAG_W-1:0]     look_tag,
   input  logic [WSEL_W-1:0]    look_word,
   output logic                 hit,
   output logic [DATA_W-1:0]    rd_word
);

   localparam int NWORDS = LINE_BITS / DATA_W;

   logic [LINE_BITS-1:0] line_q;
   logic [TAG_W-1:0]     tag_q;
   logic                 vld_q;
   logic [DATA_W-1:0]    words [NWORDS];

   always_ff @(posedge clk) begin
      if (!rst_n || wipe) begin
         line_q <= '0;
         tag_q  <= '0;
         vld_q  <= 1'b0;
      end else if (fill) begin
         line_q <= fill_line;
         tag_q  <= fill_tag;
         vld_q  <= 1'b1;
      end
   end

   for (genvar w = 0; w < NWORDS; w++) begin : g_words
      assign words[w] = line_q[w*DATA_W +: DATA_W];
   end

   assign hit     = vld_q && (tag_q == look_tag);
   assign rd_word = words[look_word];

endmodule

// File: rtl/flash_dr_guard.sv
module flash_dr_guard #(
   parameter int NCTRL      = 4,
   parameter int ID_W       = 8,
   parameter int ADDR_W     = 24,
   parameter int FLA_W      = 27,
   parameter int BLK_SHIFT  = 12,
   parameter int LINE_BYTES = 64,
   parameter int DATA_W     = 32,
   localparam int CTRL_W    = $clog2(NCTRL),
   localparam int BLK_W     = FLA_W - BLK_SHIFT,
   localparam int LINE_BITS = LINE_BYTES * 8
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    req_valid,
   output logic                    req_ready,
   input  logic [CTRL_W-1:0]       req_ctrl,
   input  logic [ID_W-1:0]         req_id,
   input  logic [ADDR_W-1:0]       req_addr,
   input  logic                    req_write,
   input  logic [NCTRL*BLK_W-1:0]  cfg_base,
   input  logic [NCTRL*BLK_W-1:0]  cfg_limit,
   input  logic [NCTRL*ID_W-1:0]   cfg_owner,
   output logic                    rsp_valid,
   output logic                    rsp_err,
   output logic [DATA_W-1:0]       rsp_data,
   output logic                    fl_req_valid,
   input  logic                    fl_req_ready,
   output logic [FLA_W-1:0]        fl_req_addr,
   input  logic                    fl_rsp_valid,
   input  logic [LINE_BITS-1:0]    fl_rsp_data
);
   import flash_dr_pkg::*;

   localparam int OFF_W  = $clog2(LINE_BYTES);
   localparam int BYTE_W = $clog2(DATA_W / 8);
   localparam int WSEL_W = OFF_W - BYTE_W;
   localparam int TAG_W  = FLA_W - OFF_W;

   // elaboration-time parameter checks
   if (NCTRL != 4) begin : g_bad_nctrl
      $error("flash_dr_guard: exactly four controllers are supported");
   end
   if (BLK_SHIFT < MIN_BLK_SHIFT) begin : g_bad_blk
      $error("flash_dr_guard: region granule below 4 KB");
   end
   if (ADDR_W > FLA_W) begin : g_bad_addr
      $error("flash_dr_guard: request address wider than linear address");
   end
   if ((1 << OFF_W) != LINE_BYTES || WSEL_W < 1) begin : g_bad_line
      $error("flash_dr_guard: line must be a power of two above one word");
   end
   if ((DATA_W % 8) != 0 || (1 << BYTE_W) * 8 != DATA_W) begin : g_bad_data
      $error("flash_dr_guard: data width must be a power-of-two byte count");
   end

   guard_st_e          st_q;
   logic [FLA_W-1:0]   pend_fla_q;
   logic [CTRL_W-1:0]  last_ctrl_q;
   logic               last_vld_q;
   logic [FLA_W-1:0]   chk_fla, look_fla;
   logic               grant, same_ctrl, accept;
   logic               c_hit, c_wipe, c_fill;
   logic [DATA_W-1:0]  c_word;

   flash_dr_region_chk #(
      .NCTRL(NCTRL), .CTRL_W(CTRL_W), .ID_W(ID_W), .ADDR_W(ADDR_W),
      .FLA_W(FLA_W), .BLK_SHIFT(BLK_SHIFT), .BLK_W(BLK_W)
   ) u_region (
      .sel       (req_ctrl),
      .req_id    (req_id),
      .req_addr  (req_addr),
      .req_write (req_write),
      .cfg_base  (cfg_base),
      .cfg_limit (cfg_limit),
      .cfg_owner (cfg_owner),
      .fla       (chk_fla),
      .grant     (grant)
   );

   assign accept    = req_valid && (st_q == ST_IDLE);
   assign same_ctrl = last_vld_q && (last_ctrl_q == req_ctrl);
   assign look_fla  = (st_q == ST_RESP) ? pend_fla_q : chk_fla;
   assign c_wipe    = accept && grant && !same_ctrl;
   assign c_fill    = (st_q == ST_WAIT) && fl_rsp_valid;

   logic unused_byte_bits;
   assign unused_byte_bits = ^look_fla[BYTE_W-1:0];

   flash_dr_line_cache #(
      .LINE_BITS(LINE_BITS), .DATA_W(DATA_W), .TAG_W(TAG_W), .WSEL_W(WSEL_W)
   ) u_cache (
      .clk       (clk),
      .rst_n     (rst_n),
      .wipe      (c_wipe),
      .fill      (c_fill),
      .fill_tag  (pend_fla_q[FLA_W-1:OFF_W]),
      .fill_line (fl_rsp_data),
      .look_tag  (look_fla[FLA_W-1:OFF_W]),
      .look_word (look_fla[OFF_W-1:BYTE_W]),
      .hit       (c_hit),
      .rd_word   (c_word)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q        <= ST_IDLE;
         pend_fla_q  <= '0;
         last_ctrl_q <= '0;
         last_vld_q  <= 1'b0;
         rsp_valid   <= 1'b0;
         rsp_err     <= 1'b0;
         rsp_data    <= '0;
      end else begin
         rsp_valid <= 1'b0;
         unique case (st_q)
            ST_IDLE: begin
               if (req_valid) begin
                  if (!grant) begin
                     rsp_valid <= 1'b1;
                     rsp_err   <= 1'b1;
                     rsp_data  <= '1;
                  end else begin
                     last_ctrl_q <= req_ctrl;
                     last_vld_q  <= 1'b1;
                     if (c_hit && same_ctrl) begin
                        rsp_valid <= 1'b1;
                        rsp_err   <= 1'b0;
                        rsp_data  <= c_word;
                     end else begin
                        pend_fla_q <= chk_fla;
                        st_q       <= ST_FETCH;
                     end
                  end
               end
            end
            ST_FETCH: if (fl_req_ready) st_q <= ST_WAIT;
            ST_WAIT:  if (fl_rsp_valid) st_q <= ST_RESP;
            ST_RESP: begin
               rsp_valid <= 1'b1;
               rsp_err   <= 1'b0;
               rsp_data  <= c_word;
               st_q      <= ST_IDLE;
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   assign req_ready    = (st_q == ST_IDLE);
   assign fl_req_valid = (st_q == ST_FETCH);
   assign fl_req_addr  = {pend_fla_q[FLA_W-1:OFF_W], {OFF_W{1'b0}}};

endmodule

// File: rtl/flash_dr_guard_chk.sv
module flash_dr_guard_chk #(
   parameter int DATA_W = 32,
   parameter int FLA_W  = 27,
   parameter int OFF_W  = 6
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_ready,
   input logic              req_write,
   input logic              rsp_valid,
   input logic              rsp_err,
   input logic [DATA_W-1:0] rsp_data,
   input logic              fl_req_valid,
   input logic              fl_req_ready,
   input logic [FLA_W-1:0]  fl_req_addr
);

   p_write_refused_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready && req_write) |=> (rsp_valid && rsp_err && !fl_req_valid));

   p_refusal_ones_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_err) |-> (rsp_data == {DATA_W{1'b1}}));

   p_fetch_aligned_r4: assert property (@(posedge clk) disable iff (!rst_n)
      fl_req_valid |-> (fl_req_addr[OFF_W-1:0] == '0));

   p_fetch_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (fl_req_valid && !fl_req_ready) |=> (fl_req_valid && $stable(fl_req_addr)));

   p_busy_in_fetch_r8: assert property (@(posedge clk) disable iff (!rst_n)
      fl_req_valid |-> (!req_ready && !rsp_valid));

   p_reset_quiet_r10: assert property (@(posedge clk)
      !rst_n |=> (!rsp_valid && !fl_req_valid && req_ready));

endmodule

bind flash_dr_guard flash_dr_guard_chk #(
   .DATA_W(DATA_W), .FLA_W(FLA_W), .OFF_W(OFF_W)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .req_valid    (req_valid),
   .req_ready    (req_ready),
   .req_write    (req_write),
   .rsp_valid    (rsp_valid),
   .rsp_err      (rsp_err),
   .rsp_data     (rsp_data),
   .fl_req_valid (fl_req_valid),
   .fl_req_ready (fl_req_ready),
   .fl_req_addr  (fl_req_addr)
);

// File: tb/flash_dr_guard_tb_top.sv
module flash_dr_guard_tb_top;

   localparam int BLK_W = 15;

   logic         clk = 1'b0;
   logic         rst_n;
   logic         req_valid, req_ready, req_write;
   logic [1:0]   req_ctrl;
   logic [7:0]   req_id;
   logic [23:0]  req_addr;
   logic [59:0]  cfg_base, cfg_limit;
   logic [31:0]  cfg_owner;
   logic         rsp_valid, rsp_err;
   logic [31:0]  rsp_data;
   logic         fl_req_valid, fl_req_ready, fl_rsp_valid;
   logic [26:0]  fl_req_addr;
   logic [511:0] fl_rsp_data;

   int checks = 0;
   int fails  = 0;
   int fl_cnt = 0;
   logic [26:0] fl_cap = '0;
   bit done = 0;

   always #10 clk = ~clk;   // 50 MHz

   flash_dr_guard dut_i (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready), .req_ctrl(req_ctrl),
      .req_id(req_id), .req_addr(req_addr), .req_write(req_write),
      .cfg_base(cfg_base), .cfg_limit(cfg_limit), .cfg_owner(cfg_owner),
      .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_data(rsp_data),
      .fl_req_valid(fl_req_valid), .fl_req_ready(fl_req_ready),
      .fl_req_addr(fl_req_addr), .fl_rsp_valid(fl_rsp_valid),
      .fl_rsp_data(fl_rsp_data)
   );

   // region setup: host 0x100..0x1FF, net 0x003..0x004,
   // mgmt 0x100..0x10F (overlaps host), embedded disabled (limit < base)
   initial begin
      cfg_base  = {BLK_W'(15'h180), BLK_W'(15'h100), BLK_W'(15'h003), BLK_W'(15'h100)};
      cfg_limit = {BLK_W'(15'h17F), BLK_W'(15'h10F), BLK_W'(15'h004), BLK_W'(15'h1FF)};
      cfg_owner = {8'h43, 8'h32, 8'h21, 8'h10};
   end

   // word k of the line at address a is {k, 0, a}
   function automatic logic [511:0] mk_line(input logic [26:0] a);
      logic [511:0] l;
      for (int k = 0; k < 16; k++) l[k*32 +: 32] = {k[3:0], 1'b0, a};
      return l;
   endfunction

   function automatic logic [31:0] exp_word(input logic [26:0] fla);
      return {fla[5:2], 1'b0, fla & 27'h7FFFFC0};
   endfunction

   // flash engine model: waits a cycle, accepts, returns the line two cycles later
   initial begin
      fl_req_ready = 1'b0;
      fl_rsp_valid = 1'b0;
      fl_rsp_data  = '0;
      forever begin
         @(negedge clk);
         if (fl_req_valid) begin
            @(negedge clk);
            fl_req_ready = 1'b1;
            fl_cap = fl_req_addr;
            fl_cnt++;
            @(negedge clk);
            fl_req_ready = 1'b0;
            @(negedge clk);
            fl_rsp_valid = 1'b1;
            fl_rsp_data  = mk_line(fl_cap);
            @(negedge clk);
            fl_rsp_valid = 1'b0;
         end
      end
   end

   task automatic check(input bit ok, input string req, input logic [31:0] act,
                        input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // one request; returns error flag, data, cycles to response, fetch count delta
   task automatic do_req(input logic [1:0] c, input logic [7:0] id,
                         input logic [23:0] a, input logic w,
                         output logic e, output logic [31:0] d,
                         output int lat, output int nf, output bit busy_ok);
      int f0;
      f0 = fl_cnt;
      busy_ok = 1;
      @(negedge clk);
      req_valid = 1'b1; req_ctrl = c; req_id = id; req_addr = a; req_write = w;
      @(negedge clk);
      req_valid = 1'b0;
      lat = 1;
      while (!rsp_valid && lat < 40) begin
         if (req_ready) busy_ok = 0;
         @(negedge clk);
         lat++;
      end
      e  = rsp_err;
      d  = rsp_data;
      nf = fl_cnt - f0;
   endtask

   typedef struct packed {
      logic [1:0]  c;
      logic [7:0]  id;
      logic [23:0] a;
      logic        w;
      logic        e;
      logic        f;
      logic [26:0] fla;
   } vec_t;

   localparam int NV = 14;
   localparam vec_t VEC [NV] = '{
      '{2'd0, 8'h10, 24'h000004, 1'b0, 1'b0, 1'b1, 27'h0100004}, // R4 R8 R11 first miss
      '{2'd0, 8'h10, 24'h000038, 1'b0, 1'b0, 1'b0, 27'h0100038}, // R7 hit word 14
      '{2'd0, 8'h11, 24'h000004, 1'b0, 1'b1, 1'b0, 27'h0},       // R2 id mismatch
      '{2'd0, 8'h10, 24'h000008, 1'b1, 1'b1, 1'b0, 27'h0},       // R1 write
      '{2'd0, 8'h10, 24'h0FFFFC, 1'b0, 1'b0, 1'b1, 27'h01FFFFC}, // R3 last word of region
      '{2'd0, 8'h10, 24'h100000, 1'b0, 1'b1, 1'b0, 27'h0},       // R3 one past limit
      '{2'd3, 8'h43, 24'h000000, 1'b0, 1'b1, 1'b0, 27'h0},       // R5 disabled region
      '{2'd0, 8'h10, 24'h000010, 1'b0, 1'b0, 1'b1, 27'h0100010}, // R8 reload line
      '{2'd2, 8'h32, 24'h000010, 1'b0, 1'b0, 1'b1, 27'h0100010}, // R9 other ctrl same line
      '{2'd2, 8'h32, 24'h000020, 1'b0, 1'b0, 1'b0, 27'h0100020}, // R7 hit after wipe refill
      '{2'd1, 8'h21, 24'h001FFC, 1'b0, 1'b0, 1'b1, 27'h0004FFC}, // R3 R4 small region top
      '{2'd1, 8'h21, 24'h002000, 1'b0, 1'b1, 1'b0, 27'h0},       // R3 beyond small region
      '{2'd2, 8'h32, 24'h000000, 1'b1, 1'b1, 1'b0, 27'h0},       // R1 R9 write from other ctrl
      '{2'd1, 8'h21, 24'h001FF0, 1'b0, 1'b0, 1'b0, 27'h0004FF0}  // R9 refusal kept cache: hit
   };

   function automatic string vec_req(input int i);
      case (i)
         0: return "R4/R11";   1: return "R7";  2: return "R2";  3: return "R1";
         4: return "R3";       5: return "R3";  6: return "R5";  7: return "R8";
         8: return "R9";       9: return "R7"; 10: return "R3"; 11: return "R3";
         12: return "R1";      default: return "R9";
      endcase
   endfunction

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      logic        e;
      logic [31:0] d;
      int          lat, nf;
      bit          busy_ok;

      rst_n = 1'b0; req_valid = 1'b0; req_ctrl = '0; req_id = '0;
      req_addr = '0; req_write = 1'b0;
      repeat (3) @(negedge clk);
      // R10 reset state
      check(req_ready == 1'b1, "R10 ready", 32'(req_ready), 1);
      check(rsp_valid == 1'b0, "R10 rsp_valid", 32'(rsp_valid), 0);
      check(fl_req_valid == 1'b0, "R10 fl_req_valid", 32'(fl_req_valid), 0);
      rst_n = 1'b1;

      for (int i = 0; i < NV; i++) begin
         vec_t v;
         string r;
         v = VEC[i];
         r = vec_req(i);
         do_req(v.c, v.id, v.a, v.w, e, d, lat, nf, busy_ok);
         check(e == v.e, $sformatf("%s v%0d err", r, i), 32'(e), 32'(v.e));
         if (v.e)
            check(d == 32'hFFFFFFFF, $sformatf("R6 %s v%0d data", r, i), d, 32'hFFFFFFFF);
         else
            check(d == exp_word(v.fla), $sformatf("R11 %s v%0d data", r, i), d, exp_word(v.fla));
         check(nf == int'(v.f), $sformatf("%s v%0d fetches", r, i), 32'(nf), 32'(v.f));
         if (v.f) begin
            check(fl_cap == (v.fla & 27'h7FFFFC0), $sformatf("R4 v%0d fetch addr", i),
                  32'(fl_cap), 32'(v.fla & 27'h7FFFFC0));
            check(lat > 1 && busy_ok, $sformatf("R8 v%0d busy while fetching", i),
                  32'(lat), 2);
         end else begin
            check(lat == 1, $sformatf("R6 R7 %s v%0d latency", r, i), 32'(lat), 1);
         end
      end

      // R10: reset empties the cache, so a line that was resident fetches again
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      check(req_ready && !rsp_valid && !fl_req_valid, "R10 mid-run reset",
            {29'd0, req_ready, rsp_valid, fl_req_valid}, 32'd4);
      rst_n = 1'b1;
      do_req(2'd1, 8'h21, 24'h001FF0, 1'b0, e, d, lat, nf, busy_ok);
      check(nf == 1, "R10 cache empty after reset", 32'(nf), 1);
      check(d == exp_word(27'h0004FF0), "R11 refetched word", d, exp_word(27'h0004FF0));

      // R5: same controller back to back after a disabled-region refusal, cache kept
      do_req(2'd3, 8'h43, 24'h000FFC, 1'b0, e, d, lat, nf, busy_ok);
      check(e == 1'b1 && nf == 0, "R5 disabled top address", {31'd0, e}, 1);
      do_req(2'd1, 8'h21, 24'h001FC0, 1'b0, e, d, lat, nf, busy_ok);
      check(nf == 0 && lat == 1, "R7 hit word 0", 32'(nf), 0);
      check(d == exp_word(27'h0004FC0), "R11 word 0", d, exp_word(27'h0004FC0));

      // R3: first byte of region granted, byte just below its base unreachable by wrap
      do_req(2'd1, 8'h21, 24'h000000, 1'b0, e, d, lat, nf, busy_ok);
      check(e == 1'b0 && nf == 1, "R3 region base", {31'd0, e}, 0);
      check(fl_cap == 27'h0003000, "R4 base fetch addr", 32'(fl_cap), 32'h3000);

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule